// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is the transfer engine of a multi-channel DMA controller. It keeps a small register set for each channel (source address, destination address, link pointer, control word and configuration word). When started, it scans the channels from the lowest index upward. A channel is served when it is enabled, not halted and allowed by its request gating. Serving a channel moves one element: a single-beat read from the source, then a single-beat write to the destination, over a valid/ready memory port.

The engine stays on one channel and moves element after element until the count runs out or the gating closes. When a count reaches zero, the engine does one of two things. If the link pointer is nonzero, it fetches a four-word descriptor from memory and reloads the channel. If the link pointer is zero, it turns the channel off. The channel's raw terminal-count flag is raised when the finished control word asks for it.

Channel registers are written and read back through a plain select/data port. The raw flags are cleared by write-one-to-clear inputs.

Top module: `lldma_engine`

## Requirements
- R1: After reset every channel register reads 0, `tc_raw`, `err_raw`, `busy` and `m_valid` are 0, and `rd_data` is 0.
- R2: While `glb_en` is 0, a `kick` is ignored: `busy` stays 0, no memory request is made and channel registers are unchanged.
- R3: A channel is served only when configuration bit 0 (enable) is 1 and bit 18 (halt) is 0. A halted channel keeps its count and makes no transfer.
- R4: The gating code is configuration bits [13:11]. The source peripheral index is bits [5:1] and the destination peripheral index is bits [10:6]. The request vector is `preq_single | preq_burst`. Code 0 needs no request, code 1 needs the destination line, code 2 needs the source line, and code 3 needs both.
- R5: One element is a read of 2^s bytes at the source, then a write of 2^d bytes at the destination. Here s is control bits [20:18] and d is control bits [23:21], each capped at 2 (`m_size` carries the capped code). Data travels in the byte lanes selected by the low address bits. Read data is zero-extended to the write width.
- R6: Control bit 26 adds the source element size to the source address after each element. Control bit 27 does the same for the destination address with the destination size. When a bit is 0, that address stays unchanged.
- R7: The remaining count is control bits [11:0]. After each element it is decremented and written back. The engine keeps serving the same channel while the count is nonzero and the gating still passes.
- R8: When the count reaches zero and the link pointer L is nonzero, the engine reads four words and reloads the channel: source from L+0, destination from L+4, control from L+12 and link from L+8, in that order.
- R9: When the count reaches zero and the link pointer is zero, configuration bit 0 is cleared.
- R10: When the count reaches zero and bit 31 of the control word that just finished is 1, that channel's `tc_raw` bit is set. A 1 on `tc_clr` clears it.
- R11: An enabled, non-halted channel with a gating code of 4 to 7 sets its `err_raw` bit. It makes no transfer, and its registers are kept. A 1 on `err_clr` clears the bit.
- R12: Channels are scanned from index 0 upward. A `kick` while `busy` is 1 is remembered, and one more full scan follows the current one.
- R13: A memory request holds `m_valid`, `m_write`, `m_addr`, `m_size` and `m_wdata` stable until `m_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global engine enable |
| kick | input | 1 | Start a scan |
| preq_single | input | NPER | Single-transfer request lines |
| preq_burst | input | NPER | Burst request lines |
| wr_en | input | 1 | Channel register write strobe |
| wr_chan | input | IW | Channel to write |
| wr_sel | input | 3 | Register select: 0 source, 1 destination, 2 link, 3 control, 4 configuration |
| wr_data | input | 32 | Write value |
| rd_chan | input | IW | Channel to read |
| rd_sel | input | 3 | Register to read, same encoding |
| rd_data | output | 32 | Read value, one cycle after the select |
| tc_clr | input | NCH | Clear terminal-count flags |
| err_clr | input | NCH | Clear error flags |
| tc_raw | output | NCH | Raw terminal-count flags |
| err_raw | output | NCH | Raw error flags |
| busy | output | 1 | Engine is scanning or transferring |
| m_valid | output | 1 | Memory request valid |
| m_write | output | 1 | 1 write, 0 read |
| m_addr | output | 32 | Byte address |
| m_size | output | 2 | Size code, bytes = 2^m_size |
| m_wdata | output | 32 | Write data, lane-aligned |
| m_ready | input | 1 | Memory accepts the request; read data valid |
| m_rdata | input | 32 | Read data, whole aligned word |

## Verification
The checks assume that the memory returns read data in the same cycle it raises `m_ready`. They also assume that `m_ready` is never raised without `m_valid`, and that element addresses are aligned to their own size. The stimulus keeps within these limits: the memory model in the bench derives `m_ready` from `m_valid` gated by a pseudo-random stall, returns the aligned word at once, and programs only naturally aligned addresses. Channel registers are written only while the engine is idle, so host writes never collide with updates made by the engine.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  localparam int CFG_EN     = 0;
  localparam int CFG_SP_LSB = 1;
  localparam int CFG_DP_LSB = 6;
  localparam int CFG_FL_LSB = 11;
  localparam int CFG_HALT   = 18;

  localparam int CTL_SW_LSB = 18;
  localparam int CTL_DW_LSB = 21;
  localparam int CTL_SINC   = 26;
  localparam int CTL_DINC   = 27;
  localparam int CTL_TCIE   = 31;

  typedef enum logic [2:0] {
    RSEL_SRC = 3'd0,
    RSEL_DST = 3'd1,
    RSEL_LNK = 3'd2,
    RSEL_CTL = 3'd3,
    RSEL_CFG = 3'd4
  } rsel_e;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] lnk;
    logic [31:0] ctl;
    logic [31:0] cfg;
  } chan_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_RD,
    ST_WR,
    ST_LD
  } eng_st_e;

  function automatic logic [1:0] size_code(input logic [2:0] f);
    return (f > 3'd2) ? 2'd2 : f[1:0];
  endfunction

endpackage

// File: rtl/lldma_chan_regs.sv
module lldma_chan_regs
  import lldma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_chan,
  input  logic [2:0]            wr_sel,
  input  logic [31:0]           wr_data,
  input  logic [IW-1:0]         rd_chan,
  input  logic [2:0]            rd_sel,
  output logic [31:0]           rd_data,
  input  logic [IW-1:0]         upd_chan,
  input  logic                  upd_src_en,
  input  logic [31:0]           upd_src,
  input  logic                  upd_dst_en,
  input  logic [31:0]           upd_dst,
  input  logic                  upd_ctl_en,
  input  logic [31:0]           upd_ctl,
  input  logic                  upd_lnk_en,
  input  logic [31:0]           upd_lnk,
  input  logic                  upd_dis,
  output chan_t [NCH-1:0]       chans
);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic host_hit, eng_hit;
    assign host_hit = wr_en && (wr_chan == IW'(c));
    assign eng_hit  = (upd_chan == IW'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        chans[c] <= '0;
      end else begin
        if (host_hit) begin
          case (wr_sel)
            RSEL_SRC: chans[c].src <= wr_data;
            RSEL_DST: chans[c].dst <= wr_data;
            RSEL_LNK: chans[c].lnk <= wr_data;
            RSEL_CTL: chans[c].ctl <= wr_data;
            RSEL_CFG: chans[c].cfg <= wr_data;
            default: ;
          endcase
        end
        if (eng_hit) begin
          if (upd_src_en) chans[c].src <= upd_src;
          if (upd_dst_en) chans[c].dst <= upd_dst;
          if (upd_ctl_en) chans[c].ctl <= upd_ctl;
          if (upd_lnk_en) chans[c].lnk <= upd_lnk;
          if (upd_dis)    chans[c].cfg[CFG_EN] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        RSEL_SRC: rd_data <= chans[rd_chan].src;
        RSEL_DST: rd_data <= chans[rd_chan].dst;
        RSEL_LNK: rd_data <= chans[rd_chan].lnk;
        RSEL_CTL: rd_data <= chans[rd_chan].ctl;
        RSEL_CFG: rd_data <= chans[rd_chan].cfg;
        default:  rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/lldma_gate.sv
module lldma_gate
  import lldma_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NPER  = 32,
  parameter int CNT_W = 12
) (
  input  chan_t [NCH-1:0] chans,
  input  logic [NPER-1:0] preq_single,
  input  logic [NPER-1:0] preq_burst,
  output logic [NCH-1:0]  go,
  output logic [NCH-1:0]  bad
);

  logic [NPER-1:0] req;
  assign req = preq_single | preq_burst;

  for (genvar c = 0; c < NCH; c++) begin : g_gate
    logic       live, s_ok, d_ok, pass;
    logic [2:0] fl;
    logic [4:0] sp, dp;

    always_comb begin
      live = chans[c].cfg[CFG_EN] && !chans[c].cfg[CFG_HALT];
      fl   = chans[c].cfg[CFG_FL_LSB +: 3];
      sp   = chans[c].cfg[CFG_SP_LSB +: 5];
      dp   = chans[c].cfg[CFG_DP_LSB +: 5];
      s_ok = req[sp];
      d_ok = req[dp];
      case (fl)
        3'd0:    pass = 1'b1;
        3'd1:    pass = d_ok;
        3'd2:    pass = s_ok;
        3'd3:    pass = s_ok && d_ok;
        default: pass = 1'b0;
      endcase
      bad[c] = live && fl[2];
      go[c]  = live && !fl[2] && pass && (chans[c].ctl[CNT_W-1:0] != '0);
    end
  end

endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
  import lldma_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int IW    = 2,
  parameter int CNT_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            glb_en,
  input  logic            kick,
  input  chan_t [NCH-1:0] chans,
  input  logic [NCH-1:0]  go,
  input  logic [NCH-1:0]  bad,
  input  logic            m_ready,
  input  logic [31:0]     m_rdata,
  output logic            m_valid,
  output logic            m_write,
  output logic [31:0]     m_addr,
  output logic [1:0]      m_size,
  output logic [31:0]     m_wdata,
  output logic            busy,
  output logic [IW-1:0]   upd_chan,
  output logic            upd_src_en,
  output logic [31:0]     upd_src,
  output logic            upd_dst_en,
  output logic [31:0]     upd_dst,
  output logic            upd_ctl_en,
  output logic [31:0]     upd_ctl,
  output logic            upd_lnk_en,
  output logic [31:0]     upd_lnk,
  output logic            upd_dis,
  output logic [NCH-1:0]  tc_set,
  output logic [NCH-1:0]  err_set
);

  eng_st_e       state;
  logic [IW-1:0] idx;
  logic          pend;
  logic [1:0]    wcnt;

  chan_t            cur;
  logic [1:0]       ssz, dsz;
  logic [CNT_W-1:0] cnt_nx;
  logic             last, hs, at_end;
  logic [31:0]      rsh, rdat;

  assign cur    = chans[idx];
  assign ssz    = size_code(cur.ctl[CTL_SW_LSB +: 3]);
  assign dsz    = size_code(cur.ctl[CTL_DW_LSB +: 3]);
  assign cnt_nx = cur.ctl[CNT_W-1:0] - 1'b1;
  assign last   = (cnt_nx == '0);
  assign hs     = m_valid && m_ready;
  assign at_end = (idx == IW'(NCH - 1));
  assign busy   = (state != ST_IDLE);
  assign rsh    = m_rdata >> {m_addr[1:0], 3'b000};

  always_comb begin
    case (ssz)
      2'd0:    rdat = {24'd0, rsh[7:0]};
      2'd1:    rdat = {16'd0, rsh[15:0]};
      default: rdat = rsh;
    endcase
  end

  always_comb begin
    upd_chan   = idx;
    upd_src_en = 1'b0;
    upd_dst_en = 1'b0;
    upd_ctl_en = 1'b0;
    upd_lnk_en = 1'b0;
    upd_dis    = 1'b0;
    upd_src    = cur.src + (32'd1 << ssz);
    upd_dst    = cur.dst + (32'd1 << dsz);
    upd_ctl    = {cur.ctl[31:CNT_W], cnt_nx};
    upd_lnk    = m_rdata;
    tc_set     = '0;
    err_set    = '0;
    case (state)
      ST_SCAN: err_set[idx] = bad[idx];
      ST_WR: if (hs) begin
        upd_src_en  = cur.ctl[CTL_SINC];
        upd_dst_en  = cur.ctl[CTL_DINC];
        upd_ctl_en  = 1'b1;
        upd_dis     = last && (cur.lnk == '0);
        tc_set[idx] = last && cur.ctl[CTL_TCIE];
      end
      ST_LD: if (hs) begin
        case (wcnt)
          2'd0: begin upd_src_en = 1'b1; upd_src = m_rdata; end
          2'd1: begin upd_dst_en = 1'b1; upd_dst = m_rdata; end
          2'd2: begin upd_ctl_en = 1'b1; upd_ctl = m_rdata; end
          default: upd_lnk_en = 1'b1;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      pend    <= 1'b0;
      wcnt    <= '0;
      m_valid <= 1'b0;
      m_write <= 1'b0;
      m_addr  <= '0;
      m_size  <= '0;
      m_wdata <= '0;
    end else begin
      if (state != ST_IDLE && kick) pend <= 1'b1;
      case (state)
        ST_IDLE: if (kick && glb_en) begin
          state <= ST_SCAN;
          idx   <= '0;
        end
        ST_SCAN: begin
          if (go[idx]) begin
            state   <= ST_RD;
            m_valid <= 1'b1;
            m_write <= 1'b0;
            m_addr  <= cur.src;
            m_size  <= ssz;
          end else if (at_end) begin
            idx <= '0;
            if (pend || kick) pend <= 1'b0;
            else              state <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_RD: if (hs) begin
          state   <= ST_WR;
          m_write <= 1'b1;
          m_addr  <= cur.dst;
          m_size  <= dsz;
          m_wdata <= rdat << {cur.dst[1:0], 3'b000};
        end
        ST_WR: if (hs) begin
          m_write <= 1'b0;
          if (last && cur.lnk != '0) begin
            state  <= ST_LD;
            m_addr <= cur.lnk;
            m_size <= 2'd2;
            wcnt   <= '0;
          end else begin
            state   <= ST_SCAN;
            m_valid <= 1'b0;
          end
        end
        ST_LD: if (hs) begin
          wcnt <= wcnt + 1'b1;
          case (wcnt)
            2'd0: m_addr <= cur.lnk + 32'd4;
            2'd1: m_addr <= cur.lnk + 32'd12;
            2'd2: m_addr <= cur.lnk + 32'd8;
            default: begin
              m_valid <= 1'b0;
              state   <= ST_SCAN;
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
  import lldma_pkg::*;
#(
  parameter  int NCH   = 4,
  parameter  int NPER  = 32,
  parameter  int CNT_W = 12,
  localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            glb_en,
  input  logic            kick,
  input  logic [NPER-1:0] preq_single,
  input  logic [NPER-1:0] preq_burst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_chan,
  input  logic [2:0]      wr_sel,
  input  logic [31:0]     wr_data,
  input  logic [IW-1:0]   rd_chan,
  input  logic [2:0]      rd_sel,
  output logic [31:0]     rd_data,
  input  logic [NCH-1:0]  tc_clr,
  input  logic [NCH-1:0]  err_clr,
  output logic [NCH-1:0]  tc_raw,
  output logic [NCH-1:0]  err_raw,
  output logic            busy,
  output logic            m_valid,
  output logic            m_write,
  output logic [31:0]     m_addr,
  output logic [1:0]      m_size,
  output logic [31:0]     m_wdata,
  input  logic            m_ready,
  input  logic [31:0]     m_rdata
);

  chan_t [NCH-1:0] chans;
  logic [NCH-1:0]  go, bad, tc_set, err_set;
  logic [IW-1:0]   upd_chan;
  logic            upd_src_en, upd_dst_en, upd_ctl_en, upd_lnk_en, upd_dis;
  logic [31:0]     upd_src, upd_dst, upd_ctl, upd_lnk;

  lldma_chan_regs #(.NCH(NCH), .IW(IW)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_chan(rd_chan), .rd_sel(rd_sel), .rd_data(rd_data),
    .upd_chan(upd_chan),
    .upd_src_en(upd_src_en), .upd_src(upd_src),
    .upd_dst_en(upd_dst_en), .upd_dst(upd_dst),
    .upd_ctl_en(upd_ctl_en), .upd_ctl(upd_ctl),
    .upd_lnk_en(upd_lnk_en), .upd_lnk(upd_lnk),
    .upd_dis(upd_dis), .chans(chans)
  );

  lldma_gate #(.NCH(NCH), .NPER(NPER), .CNT_W(CNT_W)) gate_i (
    .chans(chans), .preq_single(preq_single), .preq_burst(preq_burst),
    .go(go), .bad(bad)
  );

  lldma_seq #(.NCH(NCH), .IW(IW), .CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst(rst), .glb_en(glb_en), .kick(kick),
    .chans(chans), .go(go), .bad(bad),
    .m_ready(m_ready), .m_rdata(m_rdata),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
    .m_size(m_size), .m_wdata(m_wdata), .busy(busy),
    .upd_chan(upd_chan),
    .upd_src_en(upd_src_en), .upd_src(upd_src),
    .upd_dst_en(upd_dst_en), .upd_dst(upd_dst),
    .upd_ctl_en(upd_ctl_en), .upd_ctl(upd_ctl),
    .upd_lnk_en(upd_lnk_en), .upd_lnk(upd_lnk),
    .upd_dis(upd_dis), .tc_set(tc_set), .err_set(err_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_raw  <= '0;
      err_raw <= '0;
    end else begin
      tc_raw  <= (tc_raw & ~tc_clr) | tc_set;
      err_raw <= (err_raw & ~err_clr) | err_set;
    end
  end

endmodule

// File: rtl/lldma_engine_chk.sv
module lldma_engine_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           glb_en,
  input logic           kick,
  input logic           busy,
  input logic           m_valid,
  input logic           m_ready,
  input logic           m_write,
  input logic [31:0]    m_addr,
  input logic [1:0]     m_size,
  input logic [31:0]    m_wdata,
  input logic [NCH-1:0] tc_raw,
  input logic [NCH-1:0] err_raw
);

  p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)
                               && $stable(m_size) && $stable(m_wdata)));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !m_valid);

  p_kick_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && kick && !glb_en) |=> !busy);

  p_size_legal_r5: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_size <= 2'd2));

  p_tc_after_write_r10: assert property (@(posedge clk) disable iff (rst)
    (|(tc_raw & ~$past(tc_raw))) |-> $past(m_valid && m_ready && m_write));

  p_err_no_mem_r11: assert property (@(posedge clk) disable iff (rst)
    (|(err_raw & ~$past(err_raw))) |-> !$past(m_valid));

endmodule

bind lldma_engine lldma_engine_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .glb_en(glb_en), .kick(kick), .busy(busy),
  .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
  .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
  .tc_raw(tc_raw), .err_raw(err_raw)
);

// File: tb/lldma_engine_tb.sv
module lldma_engine_tb_top;

  localparam int NCH = 4;
  localparam int NPER = 32;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic glb_en = 1'b0, kick = 1'b0;
  logic [NPER-1:0] preq_single = '0, preq_burst = '0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_chan = '0, rd_chan = '0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NCH-1:0] tc_clr = '0, err_clr = '0, tc_raw, err_raw;
  logic busy, m_valid, m_write, m_ready;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0] m_size;

  int n_tests = 0;
  int n_fail = 0;

  logic [31:0] mem [0:511];
  logic [7:0] lfsr = 8'hA5;
  logic stall_en = 1'b0;
  int wn = 0;
  logic [31:0] wlog [0:15];

  always #4 clk = ~clk;

  assign m_rdata = mem[m_addr[10:2]];
  assign m_ready = m_valid && (!stall_en || lfsr[0]);

  lldma_engine #(.NCH(NCH), .NPER(NPER)) dut_i (
    .clk(clk), .rst(rst), .glb_en(glb_en), .kick(kick),
    .preq_single(preq_single), .preq_burst(preq_burst),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_chan(rd_chan), .rd_sel(rd_sel), .rd_data(rd_data),
    .tc_clr(tc_clr), .err_clr(err_clr), .tc_raw(tc_raw), .err_raw(err_raw),
    .busy(busy), .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
    .m_size(m_size), .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata)
  );

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (m_valid && m_ready && m_write) begin
      for (int b = 0; b < 4; b++) begin
        logic [3:0] be;
        be = (m_size == 2'd0) ? (4'b0001 << m_addr[1:0]) :
             (m_size == 2'd1) ? (4'b0011 << m_addr[1:0]) : 4'b1111;
        if (be[b]) mem[m_addr[10:2]][8*b +: 8] <= m_wdata[8*b +: 8];
      end
      if (wn < 16) wlog[wn] <= m_addr;
      wn <= wn + 1;
    end
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; glb_en = 1'b1; kick = 1'b0; stall_en = 1'b0;
    preq_single = '0; preq_burst = '0; tc_clr = '0; err_clr = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0; wn = 0;
  endtask

  task automatic wreg(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = IW'(ch); wr_sel = 3'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rreg(input int ch, input int sel, output logic [31:0] d);
    @(negedge clk);
    rd_chan = IW'(ch); rd_sel = 3'(sel);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] l, input logic [31:0] c, input logic [31:0] f);
    wreg(ch, 0, s); wreg(ch, 1, d); wreg(ch, 2, l); wreg(ch, 3, c); wreg(ch, 4, f);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic run();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    wait_idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 m_valid", 32'(m_valid), 0);
    chk("R1 tc_raw", 32'(tc_raw), 0);
    chk("R1 err_raw", 32'(err_raw), 0);
    rreg(0, 4, v); chk("R1 cfg", v, 0);
    rreg(3, 3, v); chk("R1 ctl", v, 0);
  endtask

  task automatic t_glb_off();
    logic [31:0] v;
    do_reset();
    setup(0, 32'h100, 32'h200, 0, 32'h0C480003, 32'h1);
    glb_en = 1'b0;
    run();
    repeat (10) @(negedge clk);
    chk("R2 busy", 32'(busy), 0);
    chk("R2 writes", 32'(wn), 0);
    rreg(0, 3, v); chk("R2 count kept", v, 32'h0C480003);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    do_reset();
    mem[64] = 32'hAAAA0001; mem[65] = 32'hBBBB0002; mem[66] = 32'hCCCC0003;
    mem[128] = 0; mem[129] = 0; mem[130] = 0;
    setup(0, 32'h100, 32'h200, 0, 32'h0C480003, 32'h1);
    run();
    chk("R5 word0", mem[128], 32'hAAAA0001);
    chk("R5 word2", mem[130], 32'hCCCC0003);
    chk("R7 writes", 32'(wn), 3);
    rreg(0, 3, v); chk("R7 count zero", v, 32'h0C480000);
    rreg(0, 0, v); chk("R6 src inc", v, 32'h10C);
    rreg(0, 1, v); chk("R6 dst inc", v, 32'h20C);
    rreg(0, 4, v); chk("R9 enable cleared", v, 32'h0);
    chk("R10 no tc without bit31", 32'(tc_raw), 0);
  endtask

  task automatic t_halt();
    logic [31:0] v;
    do_reset();
    setup(1, 32'h100, 32'h280, 0, 32'h0C480002, 32'h40001);
    run();
    chk("R3 halted no writes", 32'(wn), 0);
    rreg(1, 3, v); chk("R3 halted count", v, 32'h0C480002);
  endtask

  task automatic t_flow();
    do_reset();
    mem[176] = 0;
    setup(0, 32'h100, 32'h2C0, 0, 32'h00480001, 32'h941);
    run();
    chk("R4 code1 no request", 32'(wn), 0);
    preq_burst[5] = 1'b1;
    run();
    chk("R4 code1 dst request", 32'(wn), 1);
    chk("R4 code1 data", mem[176], 32'hAAAA0001);
    preq_burst = '0; preq_single[3] = 1'b1;
    setup(0, 32'h100, 32'h2C0, 0, 32'h00480001, 32'h1947);
    run();
    chk("R4 code3 src only", 32'(wn), 1);
    preq_burst[5] = 1'b1;
    run();
    chk("R4 code3 both", 32'(wn), 2);
  endtask

  task automatic t_width();
    logic [31:0] v;
    do_reset();
    mem[192] = 32'h44332211; mem[208] = 0; mem[209] = 32'hFFFFFFFF;
    setup(0, 32'h301, 32'h343, 0, 32'h04000002, 32'h1);
    run();
    chk("R5 byte lanes", mem[208], 32'h33000000);
    rreg(0, 0, v); chk("R6 byte src inc", v, 32'h303);
    rreg(0, 1, v); chk("R6 dst held", v, 32'h343);
    setup(0, 32'h302, 32'h344, 0, 32'h00440001, 32'h1);
    run();
    chk("R5 zero extend", mem[209], 32'h00004433);
  endtask

  task automatic t_desc();
    logic [31:0] v;
    do_reset();
    stall_en = 1'b1;
    mem[256] = 32'h104; mem[257] = 32'h384; mem[258] = 0; mem[259] = 32'h8C480002;
    mem[224] = 0; mem[225] = 0; mem[226] = 0;
    setup(2, 32'h100, 32'h380, 32'h400, 32'h80480001, 32'h1);
    run();
    chk("R8 first seg", mem[224], 32'hAAAA0001);
    chk("R8 linked seg a", mem[225], 32'hBBBB0002);
    chk("R8 linked seg b", mem[226], 32'hCCCC0003);
    rreg(2, 2, v); chk("R8 link word order", v, 32'h0);
    rreg(2, 3, v); chk("R8 ctl from +12", v, 32'h8C480000);
    rreg(2, 0, v); chk("R8 src reloaded", v, 32'h10C);
    rreg(2, 4, v); chk("R9 disabled after chain", v, 32'h0);
    chk("R10 tc set", 32'(tc_raw), 32'h4);
    @(negedge clk); tc_clr = 4'h4; @(negedge clk); tc_clr = '0;
    chk("R10 tc cleared", 32'(tc_raw), 0);
  endtask

  task automatic t_err();
    logic [31:0] v;
    do_reset();
    setup(3, 32'h100, 32'h3C0, 0, 32'h00480001, 32'h2801);
    run();
    chk("R11 err flag", 32'(err_raw), 32'h8);
    chk("R11 no writes", 32'(wn), 0);
    rreg(3, 4, v); chk("R11 cfg kept", v, 32'h2801);
    @(negedge clk); err_clr = 4'h8; @(negedge clk); err_clr = '0;
    chk("R11 err cleared", 32'(err_raw), 0);
  endtask

  task automatic t_order();
    do_reset();
    stall_en = 1'b1;
    setup(0, 32'h100, 32'h200, 0, 32'h00480001, 32'h100F);
    setup(1, 32'h100, 32'h240, 0, 32'h00480004, 32'h1);
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 busy mid scan", 32'(busy), 1);
    preq_single[7] = 1'b1; kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    wait_idle();
    chk("R12 rescan writes", 32'(wn), 5);
    chk("R12 first served ch1", wlog[0], 32'h240);
    chk("R12 latched ch0 last", wlog[4], 32'h200);
  endtask

  initial begin
    t_reset();
    t_glb_off();
    t_basic();
    t_halt();
    t_flow();
    t_width();
    t_desc();
    t_err();
    t_order();
    report();
  end

endmodule